// File: doc/BRIEF.md
# Paged OTG Timeout Timer

This block is a configurable interval timer for a USB dual-role controller. Software stores a 2-bit duration code for each of several timer pages through a register-style write port, and can read the stored code back for any page. Control logic outside the block selects a page and pulses a start input. The block then counts the interval that the page's stored code selects and raises a timeout flag when the interval ends.

Each page maps its four codes to its own set of protocol durations. The durations are not uniform and range from ten microseconds to over a hundred milliseconds. They are converted to clock cycles at elaboration from a clock-frequency parameter. Page 00 is unused: writes to it are dropped, it reads back as zero, and a start on it never ends in a timeout. The shortest code of the session page is the parameter `SESS_V0_US`, 18000 us by default.

The timer latches its terminal count when it starts. Rewriting a page's code while the timer runs therefore has no effect until the next start. A stop pulse or a new start clears the flag. The block has no data stream, so every pin is a plain control or status level.

Top module: `otg_tmo_timer`

## Requirements
- R1: After reset `timeout` is 0 and `rd_value` is 0 for every page.
- R2: A write with `cfg_wr` high stores `cfg_value` for `cfg_page`. The store is visible on `rd_value` from the next cycle when `rd_page` selects that page. Each page keeps its own code.
- R3: Page 00 is unused. Writes to it are ignored, it reads back 0, and a start with `tmr_page` = 00 never raises `timeout`.
- R4: Page 11 maps code 00/01/10/11 to 10 us / 100 us / 1 ms / 11 ms. If a start is sampled at edge E, `timeout` goes high at edge E+N and not before, where N = duration_us * CLK_HZ / 1,000,000.
- R5: Page 10 maps code 00/01/10/11 to 93 / 105 / 118 / 131 ms, with the same timing rule as R4.
- R6: Page 01 maps code 00/01/10/11 to SESS_V0_US (default 18 ms) / 23 / 31 / 40 ms, with the same timing rule as R4.
- R7: Once high, `timeout` stays high until an edge samples `tmr_stop` or `tmr_start`. Either of these clears it at that edge.
- R8: A stop sampled while the interval runs aborts it, and no timeout follows.
- R9: A write to the running page changes nothing in the current interval. The next start uses the new code.
- R10: A start sampled while the timer runs reloads the count, so the interval is measured from the newest start.
- R11: When `tmr_start` and `tmr_stop` are sampled together, stop wins: the timer stays idle and `timeout` stays low.
- R12: When a start and a write to the same page are sampled at the same edge, the start uses the code stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the page code store |
| cfg_page | input | 2 | Page to write |
| cfg_value | input | 2 | Duration code to store |
| rd_page | input | 2 | Page to read back |
| rd_value | output | 2 | Stored code of `rd_page` (0 for page 00) |
| tmr_start | input | 1 | Start pulse; loads the count for `tmr_page` |
| tmr_page | input | 2 | Page that a start times |
| tmr_stop | input | 1 | Stop pulse; aborts the count and clears the flag |
| timeout | output | 1 | High from the end of the interval until stop or start |

## Verification
The main function is tried with every code on every used page, and each interval is measured as an exact cycle count from the start edge. This separates a swapped code or page from a one-cycle error in the terminal compare. Against those runs stand an abort pulse, a rewrite while the timer runs, and a restart part-way through. These tell a latched limit apart from a live one, and a reload apart from a resumed count. Coincident start with stop, and start with write, fix the ordering at a single edge. Page 00 shows that an unused slot holds no state and cannot time out.

// File: rtl/otg_tmo_pkg.sv
package otg_tmo_pkg;

  localparam int PAGE_W  = 2;
  localparam int VAL_W   = 2;
  localparam int N_PAGES = 1 << PAGE_W;
  localparam int N_VALS  = 1 << VAL_W;

  // Duration in microseconds for a page/code pair; zero marks an unused slot.
  function automatic longint unsigned dur_us(input int pg, input int code,
                                             input longint unsigned sess_v0_us);
    case (pg)
      1: case (code)
           0:       return sess_v0_us;
           1:       return 64'd23000;
           2:       return 64'd31000;
           default: return 64'd40000;
         endcase
      2: case (code)
           0:       return 64'd93000;
           1:       return 64'd105000;
           2:       return 64'd118000;
           default: return 64'd131000;
         endcase
      3: case (code)
           0:       return 64'd10;
           1:       return 64'd100;
           2:       return 64'd1000;
           default: return 64'd11000;
         endcase
      default: return 64'd0;
    endcase
  endfunction

  function automatic longint unsigned dur_cyc(input int pg, input int code,
                                              input longint unsigned clk_hz,
                                              input longint unsigned sess_v0_us);
    return dur_us(pg, code, sess_v0_us) * clk_hz / 64'd1000000;
  endfunction

  function automatic int cnt_width(input longint unsigned clk_hz,
                                   input longint unsigned sess_v0_us);
    longint unsigned mx;
    mx = 1;
    for (int p = 0; p < N_PAGES; p++)
      for (int v = 0; v < N_VALS; v++)
        if (dur_cyc(p, v, clk_hz, sess_v0_us) > mx)
          mx = dur_cyc(p, v, clk_hz, sess_v0_us);
    return $clog2(mx + 1);
  endfunction

  // A page is in use when any of its codes maps to a nonzero duration.
  function automatic logic [N_PAGES-1:0] used_mask(input longint unsigned sess_v0_us);
    logic [N_PAGES-1:0] m;
    m = '0;
    for (int p = 0; p < N_PAGES; p++)
      for (int v = 0; v < N_VALS; v++)
        if (dur_us(p, v, sess_v0_us) != 0) m[p] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/otg_tmo_cfg_regs.sv
module otg_tmo_cfg_regs #(
  parameter int PAGE_W = 2,
  parameter int VAL_W  = 2,
  parameter logic [(1<<PAGE_W)-1:0] USED_MASK = '1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [PAGE_W-1:0]                wr_page,
  input  logic [VAL_W-1:0]                 wr_val,
  output logic [(1<<PAGE_W)*VAL_W-1:0]     vals
);
  localparam int N_PAGES = 1 << PAGE_W;

  for (genvar p = 0; p < N_PAGES; p++) begin : g_page
    if (USED_MASK[p]) begin : g_used
      logic [VAL_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          code_q <= '0;
        else if (wr && (wr_page == PAGE_W'(p)))
          code_q <= wr_val;
      end
      assign vals[p*VAL_W +: VAL_W] = code_q;
    end else begin : g_unused
      assign vals[p*VAL_W +: VAL_W] = '0;
    end
  end
endmodule

// File: rtl/otg_tmo_limit_lut.sv
module otg_tmo_limit_lut
  import otg_tmo_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 48000000,
  parameter longint unsigned SESS_V0_US = 18000,
  parameter int              CNT_W      = 24
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [VAL_W-1:0]  code,
  output logic [CNT_W-1:0]  limit
);
  localparam int N_ENT = N_PAGES * N_VALS;

  logic [CNT_W-1:0] tbl [N_ENT];

  for (genvar p = 0; p < N_PAGES; p++) begin : g_pg
    for (genvar v = 0; v < N_VALS; v++) begin : g_code
      localparam longint unsigned CYC = dur_cyc(p, v, CLK_HZ, SESS_V0_US);
      assign tbl[p*N_VALS + v] = CNT_W'(CYC);
    end
  end

  assign limit = tbl[{page, code}];
endmodule

// File: rtl/otg_tmo_counter.sv
module otg_tmo_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] limit,
  output logic             timeout
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             run_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (stop) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      lim_q  <= limit;
      run_q  <= (limit != '0);
      flag_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == lim_q) begin
        run_q  <= 1'b0;
        flag_q <= 1'b1;
      end
    end
  end

  assign timeout = flag_q;
endmodule

// File: rtl/otg_tmo_timer.sv
module otg_tmo_timer
  import otg_tmo_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 48000000,
  parameter longint unsigned SESS_V0_US = 18000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_page,
  input  logic [1:0] cfg_value,
  input  logic [1:0] rd_page,
  output logic [1:0] rd_value,
  input  logic       tmr_start,
  input  logic [1:0] tmr_page,
  input  logic       tmr_stop,
  output logic       timeout
);
  localparam int                 CNT_W = cnt_width(CLK_HZ, SESS_V0_US);
  localparam logic [N_PAGES-1:0] USED  = used_mask(SESS_V0_US);

  logic [N_PAGES*VAL_W-1:0] page_vals;
  logic [VAL_W-1:0]         tmr_code;
  logic [CNT_W-1:0]         start_limit;

  otg_tmo_cfg_regs #(
    .PAGE_W    (PAGE_W),
    .VAL_W     (VAL_W),
    .USED_MASK (USED)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wr_page (cfg_page),
    .wr_val  (cfg_value),
    .vals    (page_vals)
  );

  assign rd_value = page_vals[rd_page*VAL_W +: VAL_W];
  assign tmr_code = page_vals[tmr_page*VAL_W +: VAL_W];

  otg_tmo_limit_lut #(
    .CLK_HZ     (CLK_HZ),
    .SESS_V0_US (SESS_V0_US),
    .CNT_W      (CNT_W)
  ) u_lut (
    .page  (tmr_page),
    .code  (tmr_code),
    .limit (start_limit)
  );

  otg_tmo_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .stop    (tmr_stop),
    .limit   (start_limit),
    .timeout (timeout)
  );
endmodule

// File: rtl/otg_tmo_timer_chk.sv
module otg_tmo_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [1:0]       rd_page,
  input logic [1:0]       rd_value,
  input logic             tmr_start,
  input logic             tmr_stop,
  input logic             timeout,
  input logic [CNT_W-1:0] start_limit
);
  logic [CNT_W:0]   elapsed;
  logic [CNT_W-1:0] exp_lim;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      exp_lim <= '0;
      armed   <= 1'b0;
    end else if (tmr_stop) begin
      armed <= 1'b0;
    end else if (tmr_start) begin
      elapsed <= '0;
      exp_lim <= start_limit;
      armed   <= 1'b1;
    end else if (armed && !timeout) begin
      elapsed <= elapsed + 1'b1;
    end else begin
      armed <= 1'b0;
    end
  end

  // R4
  exact_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (armed && exp_lim != '0 && elapsed == {1'b0, exp_lim}));

  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_stop |=> !timeout);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |=> !timeout);

  // R7
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !tmr_start && !tmr_stop) |=> timeout);

  // R3
  unused_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_page == 2'b00) |-> (rd_value == 2'b00));

  // R2
  store_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(rd_value) || $changed(rd_page)));
endmodule

bind otg_tmo_timer otg_tmo_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .rd_page     (rd_page),
  .rd_value    (rd_value),
  .tmr_start   (tmr_start),
  .tmr_stop    (tmr_stop),
  .timeout     (timeout),
  .start_limit (start_limit)
);

// File: tb/tb_otg_tmo_timer.sv
`timescale 1ns/1ps
module tb_otg_tmo_timer;
  localparam longint unsigned CLK_HZ = 100000;
  localparam int N_VEC = 12;

  // {page, code, duration in us}
  localparam logic [35:0] VECS [N_VEC] = '{
    {2'd3, 2'd0, 32'd10},     {2'd3, 2'd1, 32'd100},
    {2'd3, 2'd2, 32'd1000},   {2'd3, 2'd3, 32'd11000},
    {2'd2, 2'd0, 32'd93000},  {2'd2, 2'd1, 32'd105000},
    {2'd2, 2'd2, 32'd118000}, {2'd2, 2'd3, 32'd131000},
    {2'd1, 2'd0, 32'd18000},  {2'd1, 2'd1, 32'd23000},
    {2'd1, 2'd2, 32'd31000},  {2'd1, 2'd3, 32'd40000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_page = '0;
  logic [1:0] cfg_value = '0;
  logic [1:0] rd_page = '0;
  logic [1:0] rd_value;
  logic tmr_start = 1'b0;
  logic [1:0] tmr_page = '0;
  logic tmr_stop = 1'b0;
  logic timeout;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  otg_tmo_timer #(.CLK_HZ(CLK_HZ), .SESS_V0_US(18000)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_page(cfg_page),
    .cfg_value(cfg_value), .rd_page(rd_page), .rd_value(rd_value),
    .tmr_start(tmr_start), .tmr_page(tmr_page), .tmr_stop(tmr_stop),
    .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] pg, input logic [1:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_page = pg; cfg_value = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_check(input logic [1:0] pg, input logic [1:0] exp, input string req);
    rd_page = pg;
    #1;
    check(rd_value == exp, req, rd_value, exp);
  endtask

  task automatic fire(input logic [1:0] pg);
    @(negedge clk);
    tmr_start = 1'b1; tmr_page = pg;
    @(negedge clk);
    tmr_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    tmr_stop = 1'b1;
    @(negedge clk);
    tmr_stop = 1'b0;
  endtask

  // Called at the negedge just after the start edge; returns edges until rise, or -1.
  task automatic measure(input int cap, output int got);
    got = -1;
    for (int el = 1; el <= cap; el++) begin
      @(negedge clk);
      if (timeout) begin
        got = el;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int got;
    int exp_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(timeout == 1'b0, "R1", timeout, 0);
    for (int p = 0; p < 4; p++) read_check(2'(p), 2'd0, "R1");

    // R3: unused page
    do_write(2'd0, 2'd3);
    read_check(2'd0, 2'd0, "R3");
    fire(2'd0);
    measure(60, got);
    check(got == -1, "R3", got, -1);

    // R4/R5/R6 with R2 readback: every code of every used page
    for (int i = 0; i < N_VEC; i++) begin
      logic [1:0] pg;
      logic [1:0] cd;
      longint unsigned us;
      string tag;
      pg = VECS[i][35:34];
      cd = VECS[i][33:32];
      us = longint'(VECS[i][31:0]);
      exp_n = int'(us * CLK_HZ / 64'd1000000);
      tag = (pg == 2'd3) ? "R4" : (pg == 2'd2) ? "R5" : "R6";
      do_write(pg, cd);
      read_check(pg, cd, "R2");
      fire(pg);
      measure(exp_n + 3, got);
      check(got == exp_n, tag, got, exp_n);
    end

    // R2: pages keep their own codes (last writes: p3=3, p2=3, p1=3)
    do_write(2'd3, 2'd1);
    read_check(2'd3, 2'd1, "R2");
    read_check(2'd1, 2'd3, "R2");

    // R7: flag holds, then stop clears it
    idle(5);
    check(timeout == 1'b1, "R7", timeout, 1);
    pulse_stop();
    check(timeout == 1'b0, "R7", timeout, 0);

    // R8: stop aborts a running interval (page 3 code 2 = 100 cycles)
    do_write(2'd3, 2'd2);
    fire(2'd3);
    idle(40);
    pulse_stop();
    measure(200, got);
    check(got == -1, "R8", got, -1);

    // R9: write while running has no effect now, applies on next start
    fire(2'd3);
    do_write(2'd3, 2'd1);
    measure(120, got);
    check(got + 2 == 100, "R9", got + 2, 100);
    fire(2'd3);
    measure(20, got);
    check(got == 10, "R9", got, 10);

    // R10: restart reloads the count
    do_write(2'd3, 2'd2);
    fire(2'd3);
    idle(30);
    fire(2'd3);
    measure(130, got);
    check(got == 100, "R10", got, 100);

    // R11: start together with stop leaves the timer idle and clears the flag
    @(negedge clk);
    tmr_start = 1'b1; tmr_stop = 1'b1; tmr_page = 2'd3;
    @(negedge clk);
    tmr_start = 1'b0; tmr_stop = 1'b0;
    check(timeout == 1'b0, "R11", timeout, 0);
    measure(150, got);
    check(got == -1, "R11", got, -1);

    // R12: start and write at the same edge use the old code (code 2 = 100)
    @(negedge clk);
    tmr_start = 1'b1; tmr_page = 2'd3;
    cfg_wr = 1'b1; cfg_page = 2'd3; cfg_value = 2'd1;
    @(negedge clk);
    tmr_start = 1'b0; cfg_wr = 1'b0;
    measure(130, got);
    check(got == 100, "R12", got, 100);
    read_check(2'd3, 2'd1, "R12");
    fire(2'd3);
    measure(20, got);
    check(got == 10, "R12", got, 10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule